// File: doc/BRIEF.md
# T1 Line Code Violation Counter

This block watches a decoded dual-rail bipolar receive stream, one symbol per qualified clock, and counts line coding errors in a saturating 16-bit accumulator. One rail marks positive pulses and the other marks negative pulses. Bipolar violations are always errors. Two mode inputs add to this. With zero-substitution decoding enabled, violations that belong to a valid eight-bit substitution code word are excluded. With excess-zero counting enabled, a long run of zeros also counts as an error: 16 zeros in plain alternate-mark mode, 8 zeros in substitution mode.

The running count is never read directly. A latch strobe copies it into an output register, presented as a high and a low byte, and restarts the running count in the same cycle. A separate clear input zeroes the running count. One-cycle flags report each bipolar violation, each recognised code word, and each zero run reaching 8 and 16.

Top module: `t1_lcv_counter`

## Requirements
- R1: A symbol is taken only in cycles with `sym_vld` high. `rx_pos` high gives a positive mark. `rx_neg` high alone gives a negative mark. Neither high gives a zero. Both high give a positive mark. Cycles with `sym_vld` low leave all state unchanged.
- R2: A bipolar violation is a mark whose polarity equals that of the most recent earlier mark since reset. The first mark after reset is never a violation. `bpv_flag` is high in the cycle after each violating symbol.
- R3: With `b8zs_en`=0 and `xz_en`=0, each bipolar violation adds one to the count.
- R4: With `b8zs_en`=0 and `xz_en`=1, a zero run adds one when it reaches 16 zeros. A longer run adds nothing more.
- R5: With `b8zs_en`=1, eight symbols 0,0,0,V,B,0,V,B form a code word. Here V is a violation, B is a non-violating mark, and at least three zeros precede the first V. Its two violations are not counted, and `cw_flag` pulses after its last symbol. Violations in a sequence that breaks off before completing are counted.
- R6: With `b8zs_en`=1 and `xz_en`=1, a zero run adds one when it reaches 8 zeros.
- R7: `zs_flag` pulses when a zero run reaches 8 zeros. `zl_flag` pulses when a zero run reaches 16 zeros. Both flags do this in every mode.
- R8: The running count saturates at FFFFh.
- R9: `cnt_latch` copies the running count to {`lat_hi`,`lat_lo`}. Events of that same cycle start the new running count.
- R10: `cnt_clr` zeroes the running count and leaves the latched output unchanged.
- R11: Reset zeroes the latched output, the running count, the flags and the polarity memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_vld | input | 1 | Symbol qualifier |
| rx_pos | input | 1 | Positive pulse rail |
| rx_neg | input | 1 | Negative pulse rail |
| b8zs_en | input | 1 | Zero-substitution decoding mode |
| xz_en | input | 1 | Excess-zero counting mode |
| cnt_latch | input | 1 | Copy count to output and restart it |
| cnt_clr | input | 1 | Zero the running count |
| lat_hi | output | CNT_W-8 | Latched count, upper byte |
| lat_lo | output | 8 | Latched count, lower byte |
| bpv_flag | output | 1 | Bipolar violation seen |
| cw_flag | output | 1 | Substitution code word recognised |
| zs_flag | output | 1 | Zero run reached 8 |
| zl_flag | output | 1 | Zero run reached 16 |

## Verification
A stale polarity memory flips the violation decision on the very next mark, so `bpv_flag` is wrong one cycle later. A stuck code-word tracker shows only when the running count is next latched, as a count that is too high or too low by one to three. A zero-run counter that fails to saturate or fails to clear shows as extra or missing `zs_flag` and `zl_flag` pulses. Counter saturation and the restart on a latch are visible only at the latch strobe after the event.

// File: rtl/lcv_pkg.sv
`timescale 1ns/1ps
package lcv_pkg;

  typedef enum logic [2:0] {
    CW_IDLE = 3'd0,
    CW_V1   = 3'd1,
    CW_B1   = 3'd2,
    CW_Z    = 3'd3,
    CW_V2   = 3'd4
  } cw_state_e;

  typedef struct packed {
    logic vld;
    logic mark;
    logic pos;
  } sym_t;

  // both rails high are taken as a positive mark
  function automatic sym_t decode_sym(input logic vld, input logic p, input logic n);
    sym_t s;
    s.vld  = vld;
    s.mark = vld & (p | n);
    s.pos  = p;
    return s;
  endfunction

  // violations held back while a candidate code word is tracked
  function automatic logic [1:0] pending_of(input cw_state_e st);
    case (st)
      CW_V1, CW_B1, CW_Z: return 2'd1;
      CW_V2:              return 2'd2;
      default:            return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/lcv_line_dec.sv
`timescale 1ns/1ps
module lcv_line_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_i,
  input  logic pos_i,
  output logic bpv_o
);
  logic seen_q;
  logic last_pos_q;

  assign bpv_o = mark_i & seen_q & (pos_i == last_pos_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      last_pos_q <= 1'b0;
    end else if (mark_i) begin
      seen_q     <= 1'b1;
      last_pos_q <= pos_i;
    end
  end

  AST_REPEAT_IS_BPV: assert property (@(posedge clk) disable iff (!rst_n)
    mark_i |=> (mark_i && pos_i == $past(pos_i)) |-> bpv_o); // R2
endmodule

// File: rtl/lcv_zero_run.sv
`timescale 1ns/1ps
module lcv_zero_run #(
  parameter int ZRUN_LONG  = 16,
  parameter int ZRUN_SHORT = 8,
  parameter int CW_LEAD    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_i,
  input  logic mark_i,
  output logic lead_ok_o,
  output logic hit_short_o,
  output logic hit_long_o
);
  localparam int ZW = $clog2(ZRUN_LONG + 1);
  localparam logic [ZW-1:0] LONG_V   = ZW'(ZRUN_LONG);
  localparam logic [ZW-1:0] LONG_M1  = ZW'(ZRUN_LONG - 1);
  localparam logic [ZW-1:0] SHORT_M1 = ZW'(ZRUN_SHORT - 1);
  localparam logic [ZW-1:0] LEAD_V   = ZW'(CW_LEAD);

  logic [ZW-1:0] run_q;

  assign lead_ok_o   = (run_q >= LEAD_V);
  assign hit_short_o = zero_i && (run_q == SHORT_M1);
  assign hit_long_o  = zero_i && (run_q == LONG_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_q <= '0;
    else if (mark_i)                     run_q <= '0;
    else if (zero_i && run_q != LONG_V)  run_q <= run_q + 1'b1;
  end

  AST_RUN_CLEARS_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    mark_i |=> !hit_short_o && !hit_long_o && !lead_ok_o); // R7
  AST_LONG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_long_o |=> !hit_long_o); // R4
endmodule

// File: rtl/lcv_cw_filter.sv
`timescale 1ns/1ps
module lcv_cw_filter import lcv_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld_i,
  input  logic       mark_i,
  input  logic       bpv_i,
  input  logic       lead_ok_i,
  input  logic       b8zs_en,
  output logic [1:0] add_o,
  output logic       cw_hit_o
);
  cw_state_e st_q, st_d;
  logic [1:0] fail_add;

  assign fail_add = pending_of(st_q) + {1'b0, bpv_i};

  always_comb begin
    st_d     = st_q;
    add_o    = 2'd0;
    cw_hit_o = 1'b0;
    if (vld_i) begin
      if (!b8zs_en) begin
        add_o = fail_add;
        st_d  = CW_IDLE;
      end else begin
        unique case (st_q)
          CW_IDLE: begin
            if (bpv_i && lead_ok_i) st_d = CW_V1;
            else                    add_o = {1'b0, bpv_i};
          end
          CW_V1: begin
            if (mark_i && !bpv_i) st_d = CW_B1;
            else begin add_o = fail_add; st_d = CW_IDLE; end
          end
          CW_B1: begin
            if (!mark_i) st_d = CW_Z;
            else begin add_o = fail_add; st_d = CW_IDLE; end
          end
          CW_Z: begin
            if (bpv_i) st_d = CW_V2;
            else begin add_o = fail_add; st_d = CW_IDLE; end
          end
          CW_V2: begin
            st_d = CW_IDLE;
            if (mark_i && !bpv_i) cw_hit_o = 1'b1;
            else                  add_o = fail_add;
          end
          default: st_d = CW_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CW_IDLE;
    else        st_q <= st_d;
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !b8zs_en) |=> st_q == CW_IDLE); // R3
  AST_CW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    cw_hit_o |=> !cw_hit_o); // R5
endmodule

// File: rtl/lcv_err_acc.sv
`timescale 1ns/1ps
module lcv_err_acc #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       add_i,
  input  logic             latch_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] lat_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [2:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? MAXV : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_o <= '0;
    end else begin
      if (latch_i) lat_o <= cnt_q;
      if (clr_i)        cnt_q <= '0;
      else if (latch_i) cnt_q <= sat_add('0, add_i);
      else              cnt_q <= sat_add(cnt_q, add_i);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !clr_i && !latch_i) |=> cnt_q == MAXV); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0); // R10
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> lat_o == $past(cnt_q)); // R9
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(lat_o)); // R10
  AST_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !latch_i) |=> cnt_q >= $past(cnt_q)); // R3
endmodule

// File: rtl/t1_lcv_counter.sv
`timescale 1ns/1ps
module t1_lcv_counter import lcv_pkg::*; #(
  parameter int CNT_W      = 16,
  parameter int ZRUN_LONG  = 16,
  parameter int ZRUN_SHORT = 8,
  parameter int CW_LEAD    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sym_vld,
  input  logic            rx_pos,
  input  logic            rx_neg,
  input  logic            b8zs_en,
  input  logic            xz_en,
  input  logic            cnt_latch,
  input  logic            cnt_clr,
  output logic [CNT_W-9:0] lat_hi,
  output logic [7:0]      lat_lo,
  output logic            bpv_flag,
  output logic            cw_flag,
  output logic            zs_flag,
  output logic            zl_flag
);
  sym_t             sym;
  logic             bpv;
  logic             lead_ok;
  logic             hit_short;
  logic             hit_long;
  logic             xz_evt;
  logic             cw_hit;
  logic [1:0]       bpv_add;
  logic [2:0]       add_tot;
  logic [CNT_W-1:0] lat_cnt;

  always_comb sym = decode_sym(sym_vld, rx_pos, rx_neg);

  lcv_line_dec u_dec (
    .clk(clk), .rst_n(rst_n), .mark_i(sym.mark), .pos_i(sym.pos), .bpv_o(bpv)
  );

  lcv_zero_run #(.ZRUN_LONG(ZRUN_LONG), .ZRUN_SHORT(ZRUN_SHORT), .CW_LEAD(CW_LEAD)) u_zrun (
    .clk(clk), .rst_n(rst_n), .zero_i(sym.vld & ~sym.mark), .mark_i(sym.mark),
    .lead_ok_o(lead_ok), .hit_short_o(hit_short), .hit_long_o(hit_long)
  );

  lcv_cw_filter u_cw (
    .clk(clk), .rst_n(rst_n), .vld_i(sym.vld), .mark_i(sym.mark), .bpv_i(bpv),
    .lead_ok_i(lead_ok), .b8zs_en(b8zs_en), .add_o(bpv_add), .cw_hit_o(cw_hit)
  );

  assign xz_evt  = xz_en & (b8zs_en ? hit_short : hit_long);
  assign add_tot = {1'b0, bpv_add} + {2'b00, xz_evt};

  lcv_err_acc #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .add_i(add_tot), .latch_i(cnt_latch), .clr_i(cnt_clr),
    .lat_o(lat_cnt)
  );

  assign lat_hi = lat_cnt[CNT_W-1:8];
  assign lat_lo = lat_cnt[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpv_flag <= 1'b0;
      cw_flag  <= 1'b0;
      zs_flag  <= 1'b0;
      zl_flag  <= 1'b0;
    end else begin
      bpv_flag <= bpv;
      cw_flag  <= cw_hit;
      zs_flag  <= hit_short;
      zl_flag  <= hit_long;
    end
  end

  AST_CW_ONLY_B8ZS: assert property (@(posedge clk) disable iff (!rst_n)
    cw_flag |-> $past(b8zs_en)); // R5
  AST_FLAG_NEEDS_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> !bpv_flag && !cw_flag && !zs_flag && !zl_flag); // R1
endmodule

// File: tb/test_t1_lcv_counter.sv
`timescale 1ns/1ps
module test_t1_lcv_counter;
  localparam real CLK_NS = 5.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_vld = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic b8zs_en = 1'b0, xz_en = 1'b0, cnt_latch = 1'b0, cnt_clr = 1'b0;
  logic [7:0] lat_hi, lat_lo;
  logic bpv_flag, cw_flag, zs_flag, zl_flag;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_NS/2.0) clk = ~clk;

  t1_lcv_counter i_t1_lcv_counter (
    .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .b8zs_en(b8zs_en), .xz_en(xz_en), .cnt_latch(cnt_latch), .cnt_clr(cnt_clr),
    .lat_hi(lat_hi), .lat_lo(lat_lo), .bpv_flag(bpv_flag), .cw_flag(cw_flag),
    .zs_flag(zs_flag), .zl_flag(zl_flag)
  );

  // symbol chars: '+' positive, '-' negative, '0' zero, '*' both rails
  typedef struct packed {
    logic         b8;
    logic         xz;
    logic [7:0]   exp;
    logic [1:0]   cw;
    logic [191:0] pat;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'd0, 2'd0, 192'("+-+-+-")},
    '{1'b0, 1'b0, 8'd2, 2'd0, 192'("++--+")},
    '{1'b0, 1'b0, 8'd2, 2'd0, 192'("+00+0-0-")},
    '{1'b0, 1'b1, 8'd1, 2'd0, 192'("0000000000000000+")},
    '{1'b0, 1'b1, 8'd1, 2'd0, 192'("00000000000000000000+-")},
    '{1'b0, 1'b0, 8'd0, 2'd0, 192'("00000000000000000000+")},
    '{1'b1, 1'b0, 8'd0, 2'd1, 192'("+000+-0-+")},
    '{1'b0, 1'b0, 8'd2, 2'd0, 192'("+000+-0-+")},
    '{1'b1, 1'b0, 8'd3, 2'd0, 192'("+000+-0--+")},
    '{1'b1, 1'b0, 8'd2, 2'd0, 192'("+000++-")},
    '{1'b1, 1'b1, 8'd1, 2'd0, 192'("00000000+-")},
    '{1'b1, 1'b1, 8'd1, 2'd1, 192'("-000-+0+-00000000+")},
    '{1'b0, 1'b1, 8'd0, 2'd0, 192'("00000000+")},
    '{1'b1, 1'b0, 8'd0, 2'd2, 192'("+000+-0-+000+-0-+")},
    '{1'b1, 1'b0, 8'd1, 2'd0, 192'("+00+-")},
    '{1'b1, 1'b0, 8'd1, 2'd0, 192'("+000+-+")},
    '{1'b1, 1'b0, 8'd1, 2'd0, 192'("+000+-00+")}
  };

  task automatic check(input bit ok, input string req, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sym_vld = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
    cnt_latch = 1'b0; cnt_clr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [7:0] ch, input logic vld, input logic lat);
    @(negedge clk);
    sym_vld = vld; cnt_latch = lat; cnt_clr = 1'b0;
    rx_pos = (ch == "+") || (ch == "*");
    rx_neg = (ch == "-") || (ch == "*");
    @(posedge clk);
    #1;
  endtask

  task automatic read_latch(output int val);
    @(negedge clk);
    sym_vld = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0; cnt_latch = 1'b1; cnt_clr = 1'b0;
    @(posedge clk);
    #1;
    val = {lat_hi, lat_lo};
    @(negedge clk);
    cnt_latch = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 190000.0);
    nerr++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int got;
    int zs_n;
    int zl_n;
    string tag;

    // table walk: modes R3..R6
    for (int v = 0; v < NV; v++) begin
      int cw_n;
      do_reset();
      b8zs_en = VEC[v].b8;
      xz_en   = VEC[v].xz;
      cw_n = 0;
      for (int c = 23; c >= 0; c--) begin
        logic [7:0] ch;
        ch = VEC[v].pat[8*c +: 8];
        if (ch != 8'd0) begin
          send(ch, 1'b1, 1'b0);
          if (cw_flag) cw_n++;
        end
      end
      read_latch(got);
      tag = VEC[v].b8 ? (VEC[v].xz ? "R6" : "R5") : (VEC[v].xz ? "R4" : "R3");
      check(got == int'(VEC[v].exp), tag, got, int'(VEC[v].exp));
      check(cw_n == int'(VEC[v].cw), "R5 code word pulses", cw_n, int'(VEC[v].cw));
    end

    // R11: reset state and polarity memory
    b8zs_en = 1'b0; xz_en = 1'b0;
    do_reset();
    #1;
    check({lat_hi, lat_lo} == 16'd0, "R11 latched after reset", {lat_hi, lat_lo}, 0);
    check({bpv_flag, cw_flag, zs_flag, zl_flag} == 4'd0, "R11 flags after reset",
          {bpv_flag, cw_flag, zs_flag, zl_flag}, 0);
    send("+", 1'b1, 1'b0);
    do_reset();
    send("+", 1'b1, 1'b0);
    check(bpv_flag == 1'b0, "R11 polarity cleared", bpv_flag, 0);
    read_latch(got);
    check(got == 0, "R11 count after reset", got, 0);

    // R2: flag timing
    do_reset();
    send("-", 1'b1, 1'b0);
    check(bpv_flag == 1'b0, "R2 first mark", bpv_flag, 0);
    send("-", 1'b1, 1'b0);
    check(bpv_flag == 1'b1, "R2 repeat mark", bpv_flag, 1);

    // R1: invalid cycles ignored, both rails positive
    do_reset();
    send("+", 1'b1, 1'b0);
    send("-", 1'b0, 1'b0);
    send("+", 1'b1, 1'b0);
    read_latch(got);
    check(got == 1, "R1 invalid symbol ignored", got, 1);
    do_reset();
    send("+", 1'b1, 1'b0);
    send("*", 1'b1, 1'b0);
    read_latch(got);
    check(got == 1, "R1 both rails positive", got, 1);

    // R9: latch with event in same cycle
    do_reset();
    send("+", 1'b1, 1'b0);
    send("+", 1'b1, 1'b1);
    check({lat_hi, lat_lo} == 16'd0, "R9 latch excludes same-cycle event", {lat_hi, lat_lo}, 0);
    read_latch(got);
    check(got == 1, "R9 event carried to new count", got, 1);

    // R10: clear keeps latched value
    do_reset();
    send("+", 1'b1, 1'b0);
    send("+", 1'b1, 1'b0);
    read_latch(got);
    check(got == 1, "R10 setup", got, 1);
    send("+", 1'b1, 1'b0);
    send("+", 1'b1, 1'b0);
    @(negedge clk);
    sym_vld = 1'b0; cnt_clr = 1'b1;
    @(posedge clk);
    #1;
    check({lat_hi, lat_lo} == 16'd1, "R10 latched kept", {lat_hi, lat_lo}, 1);
    @(negedge clk);
    cnt_clr = 1'b0;
    read_latch(got);
    check(got == 0, "R10 running cleared", got, 0);

    // R7: zero-run flags with counting off
    do_reset();
    zs_n = 0; zl_n = 0;
    for (int i = 1; i <= 20; i++) begin
      send("0", 1'b1, 1'b0);
      if (zs_flag) begin
        zs_n++;
        check(i == 8, "R7 short flag position", i, 8);
      end
      if (zl_flag) begin
        zl_n++;
        check(i == 16, "R7 long flag position", i, 16);
      end
    end
    check(zs_n == 1, "R7 short flag count", zs_n, 1);
    check(zl_n == 1, "R7 long flag count", zl_n, 1);
    read_latch(got);
    check(got == 0, "R7 nothing counted", got, 0);

    // R8: saturation
    do_reset();
    for (int i = 0; i < 65540; i++) send("+", 1'b1, 1'b0);
    read_latch(got);
    check(got == 65535, "R8 saturated", got, 65535);
    read_latch(got);
    check(got == 0, "R8 restart after latch", got, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule